// File: doc/BRIEF.md
# Variable-Term Programmable AND-OR Array

This block is the logic plane of a small programmable array device. It takes twenty array inputs: eleven dedicated data inputs, one pin that is either a clock or a twelfth logic input, and eight feedback lines from the output cells. Each input reaches every product term in both true and inverted form. Which literals each term uses is held in configuration registers, one 40-bit row per term. The ninety rows are written serially through a shift port and a row-load strobe.

The product terms are not split evenly across the outputs. Outputs 0 to 3 each OR twelve terms. Outputs 4 to 7 each OR eight terms. Ten more terms are set aside for control: eight per-output enable terms, one asynchronous preset term and one asynchronous reset term. All array outputs are combinational functions of the stored rows and the current inputs. Output cells, registers and pin drivers sit outside this block and use these signals.

Top module: `prog_term_array`

## Requirements
- R1: While `rstN` is low, every configuration row is cleared. A row that has been cleared evaluates to 1, so all of `sumOut`, `oeTerm`, `presetTerm` and `resetTerm` read 1 after reset.
- R2: On each clock edge where `cfgShift` is high, the 40-bit shift register moves up one place and `cfgBit` enters bit 0. After 40 shifts, the first bit shifted in sits at bit 39.
- R3: Array input i is `dataIn[i]` for i = 0..10, `clkPin` for i = 11, and `fb[i-12]` for i = 12..19. Row bit 2i connects the true literal of input i. Row bit 2i+1 connects its complement.
- R4: A term is the AND of every literal connected in its row. A row with no bits set evaluates to 1.
- R5: A row that connects both the true and the complement literal of the same input evaluates to 0.
- R6: `sumOut[o]` is the OR of rows 12o to 12o+11 for o = 0..3. For o = 4..7 it is the OR of rows 48+8(o-4) to 48+8(o-4)+7.
- R7: `oeTerm[o]` is row 80+o. `presetTerm` is row 88. `resetTerm` is row 89.
- R8: A clock edge with `cfgLoad` high copies the shift register into row `cfgRow`. If `cfgRow` is 90 or more, the load changes nothing.
- R9: When `clkMode` is 1, both literals of input 11 are treated as unconnected in every term, so `clkPin` has no effect. When `clkMode` is 0, `clkPin` acts as input 11.
- R10: The array outputs follow input changes within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all rows |
| dataIn | input | 11 | Dedicated array inputs 0..10 |
| clkPin | input | 1 | Dual-use pin, array input 11 |
| clkMode | input | 1 | 1: the pin is a clock and its literal is ignored |
| fb | input | 8 | Feedback lines, array inputs 12..19 |
| cfgShift | input | 1 | Shift `cfgBit` into the row shift register |
| cfgBit | input | 1 | Serial configuration data |
| cfgLoad | input | 1 | Write the shift register into a row |
| cfgRow | input | 7 | Target row of a load |
| sumOut | output | 8 | OR-sum per output |
| oeTerm | output | 8 | Output-enable term per output |
| presetTerm | output | 1 | Asynchronous preset term |
| resetTerm | output | 1 | Asynchronous reset term |

## Verification
The bench first loads a contradiction into every row, so each output reads 0. It then opens single rows at the edges of each group: rows 11, 47, 48 and 79, and rows 80, 87, 88 and 89. A design with wrong group boundaries lights the neighbouring output or misses the intended one. One row connects bit 0 and bit 39 at the same time, which catches a reversed shift direction or swapped true and complement bits. Loads to rows 90 and 127 must leave every output unchanged; a design that wraps the address would corrupt a real row. The pin literal is exercised in both modes, including a row that connects both of its literals: that row must read 1 in clock mode and 0 in input mode.

// File: rtl/prog_term_pkg.sv
package prog_term_pkg;
  localparam int ROW_AW = 7;

  typedef struct packed {
    logic              shift;
    logic              bitIn;
    logic              write;
    logic [ROW_AW-1:0] row;
    logic              pinLive;
  } cfgStrobe_t;
endpackage

// File: rtl/pta_ctrl.sv
module pta_ctrl
  import prog_term_pkg::*;
#(
  parameter int NUM_TERMS = 90
) (
  input  logic              cfgShift,
  input  logic              cfgBit,
  input  logic              cfgLoad,
  input  logic [ROW_AW-1:0] cfgRow,
  input  logic              clkMode,
  output cfgStrobe_t        strobe
);
  logic rowValid;

  assign rowValid = ({1'b0, cfgRow} < (ROW_AW + 1)'(NUM_TERMS));

  always_comb begin
    strobe.shift   = cfgShift;
    strobe.bitIn   = cfgBit;
    strobe.write   = cfgLoad && rowValid;
    strobe.row     = cfgRow;
    strobe.pinLive = !clkMode;
  end
endmodule

// File: rtl/pta_datapath.sv
module pta_datapath
  import prog_term_pkg::*;
#(
  parameter int NUM_DED     = 11,
  parameter int NUM_OUT     = 8,
  parameter int NUM_BIG     = 4,
  parameter int BIG_TERMS   = 12,
  parameter int SMALL_TERMS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [NUM_DED-1:0] dataIn,
  input  logic               clkPin,
  input  logic [NUM_OUT-1:0] fb,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_OUT-1:0] oeTerm,
  output logic               presetTerm,
  output logic               resetTerm
);
  localparam int NUM_IN    = NUM_DED + 1 + NUM_OUT;
  localparam int ROW_W     = 2 * NUM_IN;
  localparam int PIN_IDX   = NUM_DED;
  localparam int SUM_TERMS = NUM_BIG * BIG_TERMS + (NUM_OUT - NUM_BIG) * SMALL_TERMS;
  localparam int NUM_TERMS = SUM_TERMS + NUM_OUT + 2;

  logic [ROW_W-1:0]     shiftReg;
  logic [ROW_W-1:0]     cfgMem [NUM_TERMS];
  logic [NUM_IN-1:0]    lit;
  logic [NUM_IN-1:0]    ignoreIn;
  logic [NUM_TERMS-1:0] termVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {shiftReg[ROW_W-2:0], strobe.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TERMS; t++) cfgMem[t] <= '0;
    end else if (strobe.write) begin
      cfgMem[strobe.row] <= shiftReg;
    end
  end

  assign lit = {fb, clkPin, dataIn};

  always_comb begin
    ignoreIn = '0;
    ignoreIn[PIN_IDX] = !strobe.pinLive;
  end

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [NUM_IN-1:0] litOk;
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
      assign litOk[i] = ignoreIn[i] |
                        ((~cfgMem[t][2*i] | lit[i]) & (~cfgMem[t][2*i+1] | ~lit[i]));
    end
    assign termVal[t] = &litOk;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    localparam int CNT   = (o < NUM_BIG) ? BIG_TERMS : SMALL_TERMS;
    localparam int START = (o < NUM_BIG) ? o * BIG_TERMS
                                         : NUM_BIG * BIG_TERMS + (o - NUM_BIG) * SMALL_TERMS;
    assign sumOut[o] = |termVal[START +: CNT];
    assign oeTerm[o] = termVal[SUM_TERMS + o];
  end

  assign presetTerm = termVal[NUM_TERMS-2];
  assign resetTerm  = termVal[NUM_TERMS-1];
endmodule

// File: rtl/prog_term_array.sv
module prog_term_array
  import prog_term_pkg::*;
#(
  parameter int NUM_DED     = 11,
  parameter int NUM_OUT     = 8,
  parameter int NUM_BIG     = 4,
  parameter int BIG_TERMS   = 12,
  parameter int SMALL_TERMS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DED-1:0] dataIn,
  input  logic               clkPin,
  input  logic               clkMode,
  input  logic [NUM_OUT-1:0] fb,
  input  logic               cfgShift,
  input  logic               cfgBit,
  input  logic               cfgLoad,
  input  logic [ROW_AW-1:0]  cfgRow,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_OUT-1:0] oeTerm,
  output logic               presetTerm,
  output logic               resetTerm
);
  localparam int NUM_TERMS = NUM_BIG * BIG_TERMS + (NUM_OUT - NUM_BIG) * SMALL_TERMS + NUM_OUT + 2;

  cfgStrobe_t strobe;

  pta_ctrl #(.NUM_TERMS(NUM_TERMS)) u_ctrl (
    .cfgShift(cfgShift), .cfgBit(cfgBit), .cfgLoad(cfgLoad),
    .cfgRow(cfgRow), .clkMode(clkMode), .strobe(strobe)
  );

  pta_datapath #(
    .NUM_DED(NUM_DED), .NUM_OUT(NUM_OUT), .NUM_BIG(NUM_BIG),
    .BIG_TERMS(BIG_TERMS), .SMALL_TERMS(SMALL_TERMS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .clkPin(clkPin), .fb(fb), .sumOut(sumOut), .oeTerm(oeTerm),
    .presetTerm(presetTerm), .resetTerm(resetTerm)
  );
endmodule

// File: rtl/prog_term_array_chk.sv
module prog_term_array_chk
  import prog_term_pkg::*;
#(
  parameter int NUM_DED   = 11,
  parameter int NUM_OUT   = 8,
  parameter int NUM_TERMS = 90
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DED-1:0] dataIn,
  input logic               clkPin,
  input logic               clkMode,
  input logic [NUM_OUT-1:0] fb,
  input logic               cfgLoad,
  input logic [ROW_AW-1:0]  cfgRow,
  input logic               wrStrobe,
  input logic [NUM_OUT-1:0] sumOut,
  input logic [NUM_OUT-1:0] oeTerm,
  input logic               presetTerm,
  input logic               resetTerm
);
  logic [2*NUM_OUT+1:0] allOut;
  assign allOut = {sumOut, oeTerm, presetTerm, resetTerm};

  // R1: leaving reset, every row is cleared, so every output reads 1
  assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&allOut));

  // R8: a load aimed past the last row leaves all outputs unchanged
  assert_bad_row_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && ({1'b0, cfgRow} >= (ROW_AW + 1)'(NUM_TERMS))) |=>
      (!($stable(dataIn) && $stable(clkPin) && $stable(fb) && $stable(clkMode)) || $stable(allOut)));

  // R8: a row write happens only on a load request
  assert_write_needs_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> cfgLoad);

  // R9: in clock mode a toggling pin alone moves no output
  assert_pin_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode && $past(clkMode) && !$past(cfgLoad) && $stable(dataIn) && $stable(fb)) |-> $stable(allOut));
endmodule

bind prog_term_array prog_term_array_chk #(
  .NUM_DED(NUM_DED), .NUM_OUT(NUM_OUT), .NUM_TERMS(NUM_TERMS)
) u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .clkPin(clkPin), .clkMode(clkMode),
  .fb(fb), .cfgLoad(cfgLoad), .cfgRow(cfgRow), .wrStrobe(strobe.write),
  .sumOut(sumOut), .oeTerm(oeTerm), .presetTerm(presetTerm), .resetTerm(resetTerm)
);

// File: tb/prog_term_array_tb.sv
`timescale 1ns/1ps
module prog_term_array_tb;
  localparam logic [39:0] KILL  = 40'h3;
  localparam logic [39:0] EMPTY = 40'h0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] dataIn = '0;
  logic        clkPin = 1'b0;
  logic        clkMode = 1'b0;
  logic [7:0]  fb = '0;
  logic        cfgShift = 1'b0;
  logic        cfgBit = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [6:0]  cfgRow = '0;
  logic [7:0]  sumOut, oeTerm;
  logic        presetTerm, resetTerm;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  prog_term_array u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .clkPin(clkPin), .clkMode(clkMode),
    .fb(fb), .cfgShift(cfgShift), .cfgBit(cfgBit), .cfgLoad(cfgLoad), .cfgRow(cfgRow),
    .sumOut(sumOut), .oeTerm(oeTerm), .presetTerm(presetTerm), .resetTerm(resetTerm)
  );

  function automatic logic [17:0] outs();
    return {sumOut, oeTerm, presetTerm, resetTerm};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadRow(input int row, input logic [39:0] val);
    for (int b = 39; b >= 0; b--) begin
      @(negedge clk); cfgShift = 1'b1; cfgBit = val[b];
    end
    @(negedge clk); cfgShift = 1'b0; cfgLoad = 1'b1; cfgRow = 7'(row);
    @(negedge clk); cfgLoad = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset all ones", outs(), 18'h3FFFF);
  endtask

  task automatic testKillAll();
    for (int r = 0; r < 90; r++) loadRow(r, KILL);
    check("R5 contradiction rows read 0", outs(), 18'h0);
  endtask

  task automatic testLiterals();
    // row 0: dataIn[0] true (bit 0) AND fb[7] complement (bit 39)
    loadRow(0, 40'h80_0000_0001);
    dataIn = 11'h001; fb = 8'h00; #1;
    check("R2 R3 R4 term true", outs(), {8'h01, 10'h0});
    fb = 8'h80; #1;
    check("R10 R3 complement literal kills term", outs(), 18'h0);
    fb = 8'h00; dataIn = 11'h000; #1;
    check("R4 true literal kills term", outs(), 18'h0);
    loadRow(0, KILL);
  endtask

  task automatic testGroups();
    loadRow(11, EMPTY);  check("R6 row 11 drives out0", outs(), {8'h01, 10'h0}); loadRow(11, KILL);
    loadRow(12, EMPTY);  check("R6 row 12 drives out1", outs(), {8'h02, 10'h0}); loadRow(12, KILL);
    loadRow(47, EMPTY);  check("R6 row 47 drives out3", outs(), {8'h08, 10'h0}); loadRow(47, KILL);
    loadRow(48, EMPTY);  check("R6 row 48 drives out4", outs(), {8'h10, 10'h0}); loadRow(48, KILL);
    loadRow(79, EMPTY);  check("R6 row 79 drives out7", outs(), {8'h80, 10'h0}); loadRow(79, KILL);
  endtask

  task automatic testControlTerms();
    loadRow(80, EMPTY); check("R7 row 80 is oe0", outs(), {8'h00, 8'h01, 2'b00}); loadRow(80, KILL);
    loadRow(87, EMPTY); check("R7 row 87 is oe7", outs(), {8'h00, 8'h80, 2'b00}); loadRow(87, KILL);
    loadRow(88, EMPTY); check("R7 row 88 is preset", outs(), 18'h2); loadRow(88, KILL);
    loadRow(89, EMPTY); check("R7 row 89 is reset", outs(), 18'h1); loadRow(89, KILL);
  endtask

  task automatic testBadRow();
    loadRow(90, EMPTY);  check("R8 row 90 ignored", outs(), 18'h0);
    loadRow(127, EMPTY); check("R8 row 127 ignored", outs(), 18'h0);
  endtask

  task automatic testPinMode();
    // row 0: clkPin true (bit 22) AND dataIn[1] true (bit 2)
    loadRow(0, 40'h40_0004);
    dataIn = 11'h002; clkMode = 1'b0; clkPin = 1'b0; #1;
    check("R9 input mode pin low", outs(), 18'h0);
    clkPin = 1'b1; #1;
    check("R9 input mode pin high", outs(), {8'h01, 10'h0});
    clkMode = 1'b1; clkPin = 1'b0; #1;
    check("R9 clock mode pin ignored", outs(), {8'h01, 10'h0});
    // both literals of input 11 connected
    loadRow(0, 40'hC0_0000);
    #1; check("R9 clock mode both pin literals", outs(), {8'h01, 10'h0});
    clkMode = 1'b0; #1;
    check("R5 R9 input mode both pin literals", outs(), 18'h0);
    dataIn = '0;
  endtask

  task automatic testMidReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1; check("R1 reset clears loaded rows", outs(), 18'h3FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testKillAll();
    testLiterals();
    testGroups();
    testControlTerms();
    testBadRow();
    testPinMode();
    testMidReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule